// File: doc/BRIEF.md
# SCSI Asynchronous Handshake Transfer Engine

This block is the target-side data mover for an asynchronous SCSI data phase. It moves bytes over a nine-line bus, made of eight data lines and one parity line, in either direction. It paces every byte with an active-low REQ strobe that it drives and an active-low ACK answer that comes from the initiator. Software-side logic starts a transfer with a one-cycle `start` pulse, a direction bit and a byte count. When the count is used up and the initiator has released ACK, the engine raises `done` for one cycle.

When sending, the engine takes each byte from a valid/ready stream and appends an odd-parity bit. It drives all nine lines and holds REQ off for a fixed number of setup clocks. It then waits for ACK to read high and asserts REQ. When ACK is seen low, it releases REQ.

When receiving, the engine waits for ACK high and asserts REQ. When ACK is seen low, it releases REQ and captures the nine lines in the same step. The byte is presented for one cycle on the receive output. If the nine captured lines hold an even number of ones, a sticky parity error is raised, and the byte is still delivered. ACK passes through a two-flop synchronizer before any decision is made on it.

The state machine has nine states:
- `ST_IDLE` moves to `ST_TX_LOAD` or to `ST_RX_ACKHI` on an accepted start.
- `ST_TX_LOAD` moves to `ST_TX_SETUP` when a byte is taken.
- `ST_TX_SETUP` moves to `ST_TX_ACKHI` when the setup timer expires.
- `ST_TX_ACKHI` moves to `ST_TX_REQ` when ACK is high.
- `ST_TX_REQ` moves to `ST_TX_LOAD` when ACK is low, or to `ST_TAIL` if that was the last byte.
- `ST_RX_ACKHI` moves to `ST_RX_REQ` when ACK is high.
- `ST_RX_REQ` moves to `ST_RX_ACKHI` when ACK is low, or to `ST_TAIL` if that was the last byte.
- `ST_TAIL` moves to `ST_DONE` when ACK is high.
- `ST_DONE` returns to `ST_IDLE` after one cycle.

Top module: `scsi_hs_engine`

## Requirements
- R1: After reset, `req_n`=1, `bus_oe`=0, `tx_ready`=0, `rx_valid`=0, `busy`=0, `done`=0, `par_err`=0 and `len_err`=0.
- R2: In send mode (`dir_rx`=0), each streamed byte appears on `bus_out[7:0]`, in stream order, with `bus_out[8]` set so that the nine bits hold an odd number of ones. Exactly one REQ/ACK handshake occurs per byte.
- R3: `bus_out` is unchanged for at least `SETUP_CLKS` clock cycles before `req_n` falls. It stays unchanged while `req_n` is low.
- R4: `req_n` falls only after the synchronized ACK has been seen high. An ACK held low keeps REQ deasserted.
- R5: Once `req_n` is low, it stays low until the synchronized ACK is seen low, and then it rises.
- R6: In receive mode (`dir_rx`=1), one `rx_valid` pulse is produced per byte. `rx_data` equals `bus_in[7:0]` as captured when ACK is seen low.
- R7: When a received nine-bit word has an even number of ones, `par_err` is set and the byte is still delivered. `par_err` stays set until the next accepted start clears it.
- R8: A send request with an odd `xfer_len` is rejected: no transfer starts and `len_err` is set. The next accepted start clears `len_err`.
- R9: `done` is a single-cycle pulse. It comes after the last byte's handshake, once ACK has returned high, and `busy` is 0 in that cycle.
- R10: `bus_oe` is 1 throughout a send transfer and 0 during a receive transfer. `tx_ready` is 1 only while `bus_oe` is 1.
- R11: A start with `xfer_len`=0 has no effect: `busy` stays 0, no `done` occurs, and `len_err` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a transfer |
| dir_rx | input | 1 | 1 = receive from bus, 0 = send to bus |
| xfer_len | input | CNT_W | Number of bytes to move |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Engine takes `tx_data` this cycle if valid |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| bus_out | output | 9 | Parity bit and data driven onto the bus |
| bus_oe | output | 1 | Bus output enable |
| bus_in | input | 9 | Parity bit and data sampled from the bus |
| req_n | output | 1 | REQ strobe, active low |
| ack_n | input | 1 | ACK answer, active low, asynchronous |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| par_err | output | 1 | Sticky received-parity error |
| len_err | output | 1 | Sticky odd-length send rejection |

## Verification
The hardest situation to reach from the ports is a new byte that is ready while the initiator still holds ACK low from the previous one. In that situation only the ACK-high wait keeps REQ from being asserted. The bench produces this case with a hold input that forces ACK low under the initiator model. It starts a send and checks that REQ stays high for many cycles after the setup time has passed. It then releases ACK and checks that the transfer completes. The vector loop varies the initiator's response delay, so that ACK edges land at different points relative to the synchronizer and the setup timer.

// File: rtl/scsi_hs_pkg.sv
package scsi_hs_pkg;

    localparam int BYTE_W = 8;
    localparam int LINE_W = BYTE_W + 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TX_LOAD,
        ST_TX_SETUP,
        ST_TX_ACKHI,
        ST_TX_REQ,
        ST_RX_ACKHI,
        ST_RX_REQ,
        ST_TAIL,
        ST_DONE
    } hs_state_e;

    // Bit that makes the nine-line word carry an odd count of ones.
    function automatic logic odd_fill(input logic [BYTE_W-1:0] d);
        return ~(^d);
    endfunction

endpackage

// File: rtl/hs_ack_sync.sv
module hs_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/hs_setup_timer.sv
module hs_setup_timer #(
    parameter int SETUP_CLKS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(SETUP_CLKS + 1);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (run) cnt <= cnt + TW'(1);
        else          cnt <= '0;
    end

    assign expired = run && (cnt == TW'(SETUP_CLKS - 1));
endmodule

// File: rtl/hs_byte_count.sv
module hs_byte_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    remain <= '0;
        else if (load) remain <= load_val;
        else if (dec)  remain <= remain - CNT_W'(1);
    end

    assign last = (remain == CNT_W'(1));
endmodule

// File: rtl/scsi_hs_engine.sv
module scsi_hs_engine
    import scsi_hs_pkg::*;
#(
    parameter int SETUP_CLKS  = 7,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_rx,
    input  logic [CNT_W-1:0] xfer_len,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic [8:0]       bus_out,
    output logic             bus_oe,
    input  logic [8:0]       bus_in,
    output logic             req_n,
    input  logic             ack_n,
    output logic             busy,
    output logic             done,
    output logic             par_err,
    output logic             len_err
);
    hs_state_e state, state_nx;
    logic      ack_s;
    logic      tmr_exp;
    logic      cnt_last;
    logic      accept;
    logic      reject;
    logic      byte_done;
    logic      rx_take;
    logic [LINE_W-1:0] drive_r;

    hs_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ack_n), .sync_out(ack_s)
    );

    hs_setup_timer #(.SETUP_CLKS(SETUP_CLKS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(state == ST_TX_SETUP), .expired(tmr_exp)
    );

    hs_byte_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_val(xfer_len),
        .dec(byte_done), .last(cnt_last)
    );

    assign accept    = start && (state == ST_IDLE) && (xfer_len != '0)
                       && (dir_rx || !xfer_len[0]);
    assign reject    = start && (state == ST_IDLE) && !dir_rx && xfer_len[0];
    assign byte_done = ((state == ST_TX_REQ) || (state == ST_RX_REQ)) && !ack_s;
    assign rx_take   = (state == ST_RX_REQ) && !ack_s;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (accept)   state_nx = dir_rx ? ST_RX_ACKHI : ST_TX_LOAD;
            ST_TX_LOAD:  if (tx_valid) state_nx = ST_TX_SETUP;
            ST_TX_SETUP: if (tmr_exp)  state_nx = ST_TX_ACKHI;
            ST_TX_ACKHI: if (ack_s)    state_nx = ST_TX_REQ;
            ST_TX_REQ:   if (!ack_s)   state_nx = cnt_last ? ST_TAIL : ST_TX_LOAD;
            ST_RX_ACKHI: if (ack_s)    state_nx = ST_RX_REQ;
            ST_RX_REQ:   if (!ack_s)   state_nx = cnt_last ? ST_TAIL : ST_RX_ACKHI;
            ST_TAIL:     if (ack_s)    state_nx = ST_DONE;
            ST_DONE:                   state_nx = ST_IDLE;
            default:                   state_nx = ST_IDLE;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            drive_r  <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            par_err  <= 1'b0;
            len_err  <= 1'b0;
        end else begin
            state    <= state_nx;
            rx_valid <= rx_take;
            if ((state == ST_TX_LOAD) && tx_valid)
                drive_r <= {odd_fill(tx_data), tx_data};
            if (rx_take)
                rx_data <= bus_in[BYTE_W-1:0];
            if (accept)
                par_err <= 1'b0;
            else if (rx_take && !(^bus_in))
                par_err <= 1'b1;
            if (accept)      len_err <= 1'b0;
            else if (reject) len_err <= 1'b1;
        end
    end

    // Moore outputs
    always_comb begin
        req_n    = 1'b1;
        bus_oe   = 1'b0;
        tx_ready = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        unique case (state)
            ST_IDLE:     busy = 1'b0;
            ST_TX_LOAD:  begin bus_oe = 1'b1; tx_ready = 1'b1; end
            ST_TX_SETUP: bus_oe = 1'b1;
            ST_TX_ACKHI: bus_oe = 1'b1;
            ST_TX_REQ:   begin bus_oe = 1'b1; req_n = 1'b0; end
            ST_RX_ACKHI: ;
            ST_RX_REQ:   req_n = 1'b0;
            ST_TAIL:     ;
            ST_DONE:     begin busy = 1'b0; done = 1'b1; end
            default:     busy = 1'b0;
        endcase
    end

    assign bus_out = drive_r;
endmodule

// File: rtl/scsi_hs_engine_chk.sv
module scsi_hs_engine_chk #(
    parameter int SETUP_CLKS = 7
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_n,
    input logic       ack_s,
    input logic [8:0] bus_out,
    input logic       bus_oe,
    input logic       tx_ready,
    input logic       done,
    input logic       busy,
    input logic       par_err,
    input logic       rx_valid
);
    localparam int SW = $clog2(SETUP_CLKS + 2) + 1;
    logic [SW-1:0] stab;
    logic [8:0]    bus_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stab     <= '0;
            bus_prev <= '0;
        end else begin
            bus_prev <= bus_out;
            if (bus_out != bus_prev)      stab <= '0;
            else if (stab != '1)          stab <= stab + SW'(1);
        end
    end

    // R3
    setup_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(req_n) && bus_oe) |-> (stab >= SW'(SETUP_CLKS)));

    // R3
    hold_while_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && $past(!req_n) && bus_oe) |-> $stable(bus_out));

    // R4
    req_after_ack_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_n) |-> $past(ack_s));

    // R5
    req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_n) |-> !$past(ack_s));

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && ack_s) |=> !req_n);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    par_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_err) |-> rx_valid);

    // R10
    ready_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> bus_oe);
endmodule

bind scsi_hs_engine scsi_hs_engine_chk #(.SETUP_CLKS(SETUP_CLKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .ack_s(ack_s),
    .bus_out(bus_out), .bus_oe(bus_oe), .tx_ready(tx_ready),
    .done(done), .busy(busy), .par_err(par_err), .rx_valid(rx_valid)
);

// File: tb/scsi_hs_engine_tb.sv
module scsi_hs_engine_tb;
    localparam int SETUP = 7;
    localparam int CW    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic dir_rx = 1'b0;
    logic [CW-1:0] xfer_len = '0;
    logic [7:0] tx_data = '0;
    logic tx_valid = 1'b0;
    logic tx_ready, rx_valid, bus_oe, req_n, busy, done, par_err, len_err;
    logic [7:0] rx_data;
    logic [8:0] bus_out;
    logic [8:0] bus_in = '0;
    logic host_ack = 1'b1;
    logic ack_hold = 1'b0;
    logic ack_n;

    assign ack_n = host_ack & ~ack_hold;

    always #5 clk = ~clk;

    scsi_hs_engine #(.SETUP_CLKS(SETUP), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_rx(dir_rx), .xfer_len(xfer_len),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .bus_out(bus_out), .bus_oe(bus_oe),
        .bus_in(bus_in), .req_n(req_n), .ack_n(ack_n), .busy(busy), .done(done),
        .par_err(par_err), .len_err(len_err)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return seed + 8'(i * 19);
    endfunction

    // Initiator model settings, written by the main sequence only
    logic       host_rx = 1'b0;
    logic [7:0] host_seed = '0;
    int         host_bad = 99;
    int         host_base = 0;
    int         host_dly = 1;

    // Bus stability tracker
    int         stab = 0;
    logic [8:0] bus_prev = '0;
    always @(negedge clk) begin
        if (bus_out !== bus_prev) stab = 0;
        else stab = stab + 1;
        bus_prev = bus_out;
    end

    // Initiator model
    int         hcnt = 0;
    logic [8:0] cap [256];
    int         cap_stab [256];
    always begin
        @(negedge clk);
        if (!req_n) begin
            if (host_rx) begin
                logic [7:0] b;
                logic       p;
                b = pat(host_seed, hcnt - host_base);
                p = ~(^b);
                if ((hcnt - host_base) == host_bad) p = ~p;
                bus_in = {p, b};
            end else begin
                cap[hcnt[7:0]] = bus_out;
                cap_stab[hcnt[7:0]] = stab;
            end
            repeat (host_dly) @(negedge clk);
            host_ack = 1'b0;
            while (!req_n) @(negedge clk);
            repeat (host_dly) @(negedge clk);
            host_ack = 1'b1;
            hcnt = hcnt + 1;
        end
    end

    // Receive and done monitors
    int         rxn = 0;
    logic [7:0] rxcap [256];
    int         done_n = 0;
    logic       done_busy = 1'b0;
    logic       done_ackn = 1'b0;
    always @(negedge clk) begin
        if (rx_valid) begin
            rxcap[rxn[7:0]] = rx_data;
            rxn = rxn + 1;
        end
        if (done) begin
            done_n = done_n + 1;
            done_busy = busy;
            done_ackn = ack_n;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
        $finish;
    end

    // {dir_rx, len[4:0], seed[7:0], bad_index[4:0]}; bad index 31 = none
    localparam int NV = 7;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 5'd2, 8'hA5, 5'd31},
        {1'b0, 5'd4, 8'h00, 5'd31},
        {1'b0, 5'd6, 8'hFE, 5'd31},
        {1'b1, 5'd1, 8'h3C, 5'd31},
        {1'b1, 5'd5, 8'h80, 5'd2},
        {1'b1, 5'd3, 8'h7F, 5'd31},
        {1'b0, 5'd2, 8'hF0, 5'd31}
    };

    task automatic feed(input logic [7:0] seed, input int n);
        for (int i = 0; i < n; i++) begin
            tx_data  = pat(seed, i);
            tx_valid = 1'b1;
            while (!tx_ready) @(negedge clk);
            @(negedge clk);
            tx_valid = 1'b0;
        end
    endtask

    task automatic kick(input logic d, input int n);
        @(negedge clk);
        start = 1'b1; dir_rx = d; xfer_len = CW'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_n === 1'b1 && bus_oe === 1'b0 && tx_ready === 1'b0 && rx_valid === 1'b0,
            "R1 bus idle", {req_n, bus_oe, tx_ready, rx_valid}, 4'b1000);
        chk(busy === 1'b0 && done === 1'b0 && par_err === 1'b0 && len_err === 1'b0,
            "R1 flags", {busy, done, par_err, len_err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8 odd send length rejected
        kick(1'b0, 3);
        repeat (10) @(negedge clk);
        chk(len_err === 1'b1, "R8 len_err set", len_err, 1);
        chk(busy === 1'b0 && req_n === 1'b1 && bus_oe === 1'b0, "R8 no transfer",
            {busy, req_n, bus_oe}, 3'b010);

        // R11 zero length ignored
        begin
            int d0;
            d0 = done_n;
            kick(1'b0, 0);
            repeat (10) @(negedge clk);
            chk(busy === 1'b0 && done_n == d0, "R11 no activity", done_n - d0, 0);
            chk(len_err === 1'b1, "R11 len_err kept", len_err, 1);
        end

        // R4 ACK held low blocks REQ
        begin
            int hb, db;
            host_rx = 1'b0; host_seed = 8'h55; host_dly = 2;
            hb = hcnt; host_base = hcnt; db = done_n;
            ack_hold = 1'b1;
            kick(1'b0, 2);
            chk(len_err === 1'b0, "R8 len_err cleared", len_err, 0);
            feed(8'h55, 1);
            repeat (SETUP + 30) @(negedge clk);
            chk(req_n === 1'b1, "R4 REQ withheld while ACK low", req_n, 1);
            chk(bus_out === {~(^pat(8'h55, 0)), pat(8'h55, 0)}, "R2 byte held",
                bus_out, {~(^pat(8'h55, 0)), pat(8'h55, 0)});
            ack_hold = 1'b0;
            feed(8'h55, 0);
            tx_data = pat(8'h55, 1); tx_valid = 1'b1;
            while (!tx_ready) @(negedge clk);
            @(negedge clk);
            tx_valid = 1'b0;
            while (done_n == db) @(negedge clk);
            chk(hcnt - hb == 2, "R4 transfer resumes", hcnt - hb, 2);
        end

        // Vector loop
        for (int v = 0; v < NV; v++) begin
            logic       d;
            int         n, bad, hb, rb, db, minst;
            logic [7:0] seed;
            d = VEC[v][18]; n = int'(VEC[v][17:13]); seed = VEC[v][12:5]; bad = int'(VEC[v][4:0]);
            host_rx = d; host_seed = seed; host_bad = bad; host_dly = 1 + (v % 3);
            hb = hcnt; host_base = hcnt; rb = rxn; db = done_n;
            kick(d, n);
            if (!d) begin
                chk(bus_oe === 1'b1, "R10 drive on send", bus_oe, 1);
                feed(seed, n);
            end else begin
                @(negedge clk);
                chk(bus_oe === 1'b0 && tx_ready === 1'b0, "R10 no drive on receive",
                    {bus_oe, tx_ready}, 0);
            end
            while (done_n == db) @(negedge clk);
            chk(done_busy === 1'b0 && done_ackn === 1'b1, "R9 done after ACK release",
                {done_busy, done_ackn}, 2'b01);
            @(negedge clk);
            chk(done_n == db + 1, "R9 single done", done_n - db, 1);
            chk(hcnt - hb == n, "R2 handshake count", hcnt - hb, n);
            if (!d) begin
                minst = 1000;
                for (int i = 0; i < n; i++) begin
                    logic [8:0] e;
                    e = {~(^pat(seed, i)), pat(seed, i)};
                    chk(cap[(hb + i) % 256] === e, "R2 sent word", cap[(hb + i) % 256], e);
                    if (cap_stab[(hb + i) % 256] < minst) minst = cap_stab[(hb + i) % 256];
                end
                chk(minst >= SETUP, "R3 setup before REQ", minst, SETUP);
            end else begin
                chk(rxn - rb == n, "R6 rx strobe count", rxn - rb, n);
                for (int i = 0; i < n; i++)
                    chk(rxcap[(rb + i) % 256] === pat(seed, i), "R6 received byte",
                        rxcap[(rb + i) % 256], pat(seed, i));
                chk(par_err === (bad < n), "R7 parity flag", par_err, (bad < n));
                repeat (5) @(negedge clk);
                chk(par_err === (bad < n), "R7 flag sticky", par_err, (bad < n));
            end
            chk(req_n === 1'b1 && busy === 1'b0, "R5 REQ released at end", {req_n, busy}, 2'b10);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule